// File: doc/BRIEF.md
# Two-Step Operand/Execute Datapath

This block is the arithmetic core of a small 16-bit processor. It takes one micro-command per clock. In the first clock, two source registers from an internal register file are captured into a pair of operand registers, R and S. In the second clock, those operands pass through an ALU and then through a post-ALU stage. That stage can shift, swap bytes (optionally zeroing one byte), or apply a packed-BCD correction. The final value appears on the U-bus and is stored into a chosen destination register at the next edge.

A result can come back as an operand without a round trip through the register file. It can be requested explicitly with a per-operand feedback flag. The block also forwards it automatically when a command reads a register that the command just ahead of it is about to write. A separate load port places external values into the register file. When the load port and the pipeline write the same cycle, the pipeline write takes priority.

Top module: `rsp_datapath`

## Requirements
- R1: After reset, all eight registers hold 0 and `u_valid` is low.
- R2: A command accepted at clock edge N puts its result on `u_bus` with `u_valid` high for the cycle after edge N. When `cmd_wr` is set, the result is stored into `cmd_dst` at edge N+1.
- R3: `cmd_alu` selects the ALU function. The codes are 0 add R+S, 1 subtract R-S, 2 AND, 3 OR, 4 XOR, 5 pass R, 6 pass S, 7 increment R. `carry_flag` is the carry out for add and increment, and is 1 for subtract when R >= S unsigned. It is 0 for codes 2 to 6.
- R4: `cmd_post` selects the post-ALU function. The codes are 0 pass, 1 shift left one with zero fill, 2 shift right one with zero fill, 3 swap bytes, 4 swap and clear the upper byte, 5 swap and clear the lower byte, 6 decimal correct. Code 7 behaves as pass.
- R5: With code 6 after an add of two packed-BCD operands, `u_bus` is the packed-BCD sum of the four low decimal digits. `carry_flag` is 1 when the decimal sum reaches 10000.
- R6: `zero_flag` is 1 exactly when the `u_bus` value is 0.
- R7: A register changes only when it is a destination with `cmd_wr` set, or when it is loaded. A command with `cmd_wr` low writes nothing.
- R8: A command that reads a register written by the command one cycle ahead of it sees that new value.
- R9: `cmd_rfb` and `cmd_sfb` replace the R or S operand with the previous command's U-bus result.
- R10: The load port writes `ld_data` into `ld_addr` at the edge. A pipeline store in the same cycle wins.
- R11: A cycle without `cmd_valid` produces `u_valid` low in the following cycle and leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Micro-command present this cycle |
| cmd_alu | input | 3 | ALU function code |
| cmd_post | input | 3 | Post-ALU function code |
| cmd_rsel | input | 3 | Register read as R operand |
| cmd_ssel | input | 3 | Register read as S operand |
| cmd_rfb | input | 1 | Use previous result as R |
| cmd_sfb | input | 1 | Use previous result as S |
| cmd_wr | input | 1 | Store result |
| cmd_dst | input | 3 | Destination register |
| ld_valid | input | 1 | External load request |
| ld_addr | input | 3 | Load destination |
| ld_data | input | 16 | Load value |
| u_valid | output | 1 | U-bus carries a result |
| u_bus | output | 16 | Result value |
| carry_flag | output | 1 | Carry of the result |
| zero_flag | output | 1 | Result equals zero |

## Verification
Every result is due one cycle after the edge that accepts its command. The scoreboard therefore pushes an expected item when a command is driven and pops it at the next falling edge on which `u_valid` is seen. Register contents show up only through later commands that pass the register through, so stores are checked one command later. Forwarding and feedback are checked by issuing commands on consecutive cycles. The idle behaviour is checked by sampling `u_valid` one falling edge after a cycle without a command.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PR, ALU_PS, ALU_INC
  } alu_op_e;

  typedef enum logic [2:0] {
    PO_PASS, PO_SHL, PO_SHR, PO_SWAP, PO_SWAP_CU, PO_SWAP_CL, PO_DEC, PO_RSV
  } post_op_e;
endpackage

// File: rtl/rsp_regfile.sv
module rsp_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (we && (waddr == AW'(g)))            mem[g] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rsp_alu.sv
module rsp_alu
  import rsp_pkg::*;
#(
  parameter int W   = 16,
  localparam int NN = W / 4
) (
  input  logic [W-1:0]  r,
  input  logic [W-1:0]  s,
  input  alu_op_e       op,
  output logic [W-1:0]  res,
  output logic          carry,
  output logic [NN-1:0] nib_c
);
  logic [W:0]   sum;
  logic [W-1:0] sb;
  logic         arith;

  // carry into bit k of an add is operand_a ^ operand_b ^ sum at bit k
  function automatic logic [NN-1:0] nibble_carries(logic [W-1:0] a, logic [W-1:0] b,
                                                   logic [W:0] t);
    logic [NN-1:0] nc;
    for (int i = 0; i < NN - 1; i++) nc[i] = a[4*i+4] ^ b[4*i+4] ^ t[4*i+4];
    nc[NN-1] = t[W];
    return nc;
  endfunction

  always_comb begin
    sb    = '0;
    sum   = '0;
    arith = 1'b1;
    res   = '0;
    unique case (op)
      ALU_ADD: begin sb = s;  sum = {1'b0, r} + {1'b0, sb}; end
      ALU_SUB: begin sb = ~s; sum = {1'b0, r} + {1'b0, sb} + (W+1)'(1); end
      ALU_INC: begin sb = '0; sum = {1'b0, r} + (W+1)'(1); end
      default: arith = 1'b0;
    endcase
    unique case (op)
      ALU_AND: res = r & s;
      ALU_OR:  res = r | s;
      ALU_XOR: res = r ^ s;
      ALU_PR:  res = r;
      ALU_PS:  res = s;
      default: res = sum[W-1:0];
    endcase
    carry = arith & sum[W];
    nib_c = arith ? nibble_carries(r, sb, sum) : '0;
  end
endmodule

// File: rtl/rsp_post.sv
module rsp_post
  import rsp_pkg::*;
#(
  parameter int W   = 16,
  localparam int NN = W / 4,
  localparam int H  = W / 2
) (
  input  logic [W-1:0]  a,
  input  post_op_e      op,
  input  logic [NN-1:0] nib_c,
  input  logic          carry_in,
  output logic [W-1:0]  y,
  output logic          carry_out
);
  logic [W:0] dec_v;

  // low nibble first: +6 when a digit exceeds 9 or the add carried out of it
  function automatic logic [W:0] dec_adjust(logic [W-1:0] v, logic [NN-1:0] nc);
    logic [W-1:0] o;
    logic [4:0]   n;
    logic         c;
    o = '0;
    c = 1'b0;
    for (int i = 0; i < NN; i++) begin
      n = {1'b0, v[4*i +: 4]} + {4'b0, c};
      if (n > 5'd9 || nc[i]) n = n + 5'd6;
      o[4*i +: 4] = n[3:0];
      c = n[4];
    end
    return {c, o};
  endfunction

  assign dec_v = dec_adjust(a, nib_c);

  always_comb begin
    carry_out = carry_in;
    unique case (op)
      PO_SHL:     y = {a[W-2:0], 1'b0};
      PO_SHR:     y = {1'b0, a[W-1:1]};
      PO_SWAP:    y = {a[H-1:0], a[W-1:H]};
      PO_SWAP_CU: y = {{H{1'b0}}, a[W-1:H]};
      PO_SWAP_CL: y = {a[H-1:0], {H{1'b0}}};
      PO_DEC: begin
        y         = dec_v[W-1:0];
        carry_out = carry_in | dec_v[W];
      end
      default:    y = a;
    endcase
  end
endmodule

// File: rtl/rsp_datapath.sv
module rsp_datapath
  import rsp_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG),
  localparam int NN  = W / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_alu,
  input  logic [2:0]    cmd_post,
  input  logic [AW-1:0] cmd_rsel,
  input  logic [AW-1:0] cmd_ssel,
  input  logic          cmd_rfb,
  input  logic          cmd_sfb,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_dst,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  output logic          u_valid,
  output logic [W-1:0]  u_bus,
  output logic          carry_flag,
  output logic          zero_flag
);
  // stage-1 state: operand registers and the captured command
  logic [W-1:0]  r_q, s_q;
  logic          s1_valid, s1_wr;
  logic [AW-1:0] s1_dst;
  alu_op_e       s1_alu;
  post_op_e      s1_post;

  // named internal events
  logic [W-1:0]  rd_a, rd_b, r_in, s_in;
  logic          hit_r, hit_s, fwd_r, fwd_s;
  logic          store, rf_we;
  logic [AW-1:0] rf_waddr;
  logic [W-1:0]  rf_wdata;
  logic [W-1:0]  alu_res;
  logic          alu_c;
  logic [NN-1:0] alu_nc;

  assign store    = s1_valid & s1_wr;
  assign rf_we    = store | ld_valid;
  assign rf_waddr = store ? s1_dst : ld_addr;
  assign rf_wdata = store ? u_bus  : ld_data;

  rsp_regfile #(.W(W), .NREG(NREG)) rf_i (
    .clk, .rst_n, .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(cmd_rsel), .raddr_b(cmd_ssel), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  assign hit_r = store && (s1_dst == cmd_rsel);
  assign hit_s = store && (s1_dst == cmd_ssel);
  assign fwd_r = cmd_rfb | hit_r;
  assign fwd_s = cmd_sfb | hit_s;
  assign r_in  = fwd_r ? u_bus : rd_a;
  assign s_in  = fwd_s ? u_bus : rd_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_dst   <= '0;
      s1_alu   <= ALU_ADD;
      s1_post  <= PO_PASS;
      r_q      <= '0;
      s_q      <= '0;
    end else begin
      s1_valid <= cmd_valid;
      if (cmd_valid) begin
        r_q     <= r_in;
        s_q     <= s_in;
        s1_wr   <= cmd_wr;
        s1_dst  <= cmd_dst;
        s1_alu  <= alu_op_e'(cmd_alu);
        s1_post <= post_op_e'(cmd_post);
      end
    end
  end

  rsp_alu #(.W(W)) alu_i (
    .r(r_q), .s(s_q), .op(s1_alu), .res(alu_res), .carry(alu_c), .nib_c(alu_nc)
  );

  rsp_post #(.W(W)) post_i (
    .a(alu_res), .op(s1_post), .nib_c(alu_nc), .carry_in(alu_c),
    .y(u_bus), .carry_out(carry_flag)
  );

  assign u_valid   = s1_valid;
  assign zero_flag = (u_bus == '0);
endmodule

// File: rtl/rsp_chk.sv
module rsp_chk
  import rsp_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         u_valid,
  input logic [W-1:0] u_bus,
  input logic [W-1:0] s_q,
  input alu_op_e      s1_alu,
  input post_op_e     s1_post,
  input logic         s1_wr,
  input logic         rf_we,
  input logic         ld_valid
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !u_valid);

  // R2
  issue_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> u_valid);

  // R11
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !u_valid);

  // R3
  pass_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && s1_alu == ALU_PS && s1_post == PO_PASS) |-> (u_bus == s_q));

  // R4
  swap_cu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && s1_post == PO_SWAP_CU) |-> (u_bus[W-1:W/2] == '0));

  // R4
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && s1_post == PO_SHL) |-> !u_bus[0]);

  // R7
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((u_valid && s1_wr) || ld_valid));
endmodule

bind rsp_datapath rsp_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .u_valid(u_valid),
  .u_bus(u_bus), .s_q(s_q), .s1_alu(s1_alu), .s1_post(s1_post),
  .s1_wr(s1_wr), .rf_we(rf_we), .ld_valid(ld_valid)
);

// File: tb/rsp_datapath_tb.sv
module rsp_datapath_tb_top;
  localparam logic [2:0] A_ADD = 3'd0, A_SUB = 3'd1, A_AND = 3'd2, A_OR = 3'd3,
                         A_XOR = 3'd4, A_PR = 3'd5, A_PS = 3'd6, A_INC = 3'd7;
  localparam logic [2:0] P_PASS = 3'd0, P_SHL = 3'd1, P_SHR = 3'd2, P_SWAP = 3'd3,
                         P_SCU = 3'd4, P_SCL = 3'd5, P_DEC = 3'd6, P_RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_rfb = 1'b0, cmd_sfb = 1'b0, cmd_wr = 1'b0;
  logic [2:0]  cmd_alu = '0, cmd_post = '0, cmd_rsel = '0, cmd_ssel = '0, cmd_dst = '0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        u_valid, carry_flag, zero_flag;
  logic [15:0] u_bus;

  always #5 clk = ~clk;

  rsp_datapath dut_i (.*);

  typedef struct {
    logic [15:0] v;
    logic        c;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model[8];
  logic [15:0] last_u = '0;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 0;

  function automatic int bcd2int(logic [15:0] b);
    return b[15:12] * 1000 + b[11:8] * 100 + b[7:4] * 10 + b[3:0];
  endfunction

  function automatic logic [15:0] int2bcd(int n);
    return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  // expected result computed from the requirement text, as {carry, value}
  function automatic logic [16:0] predict(logic [2:0] alu, logic [2:0] post,
                                          logic [15:0] r, logic [15:0] s);
    int          t;
    logic [15:0] v;
    logic        c;
    c = 1'b0;
    case (alu)
      A_ADD:   begin t = int'(r) + int'(s); v = 16'(t); c = (t > 65535); end
      A_SUB:   begin v = 16'(int'(r) - int'(s)); c = (r >= s); end
      A_AND:   v = r & s;
      A_OR:    v = r | s;
      A_XOR:   v = r ^ s;
      A_PR:    v = r;
      A_PS:    v = s;
      default: begin v = 16'(int'(r) + 1); c = (r == 16'hFFFF); end
    endcase
    case (post)
      P_SHL:  v = v << 1;
      P_SHR:  v = v >> 1;
      P_SWAP: v = {v[7:0], v[15:8]};
      P_SCU:  v = {8'h00, v[15:8]};
      P_SCL:  v = {v[7:0], 8'h00};
      P_DEC: begin
        t = bcd2int(r) + bcd2int(s);
        v = int2bcd(t);
        c = (t >= 10000);
      end
      default: ;
    endcase
    return {c, v};
  endfunction

  task automatic quiet();
    cmd_valid = 0; cmd_rfb = 0; cmd_sfb = 0; cmd_wr = 0; ld_valid = 0;
  endtask

  task automatic issue(string tag, logic [2:0] alu, logic [2:0] post,
                       logic [2:0] rs, logic [2:0] ss, bit rfb, bit sfb,
                       bit wr, logic [2:0] dst);
    logic [15:0] r, s;
    logic [16:0] e;
    @(negedge clk);
    quiet();
    cmd_valid = 1; cmd_alu = alu; cmd_post = post; cmd_rsel = rs; cmd_ssel = ss;
    cmd_rfb = rfb; cmd_sfb = sfb; cmd_wr = wr; cmd_dst = dst;
    r = rfb ? last_u : model[rs];
    s = sfb ? last_u : model[ss];
    e = predict(alu, post, r, s);
    sb_q.push_back('{v: e[15:0], c: e[16], tag: tag});
    last_u = e[15:0];
    if (wr) model[dst] = e[15:0];
  endtask

  task automatic load(logic [2:0] a, logic [15:0] d, bit store_wins);
    @(negedge clk);
    quiet();
    ld_valid = 1; ld_addr = a; ld_data = d;
    if (!store_wins) model[a] = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      quiet();
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: results are due one falling edge after the accepting edge
  always @(negedge clk) begin
    if (rst_n && u_valid) begin
      if (sb_q.size() == 0) begin
        check("R2 unexpected result", 32'(u_bus), 32'hDEAD);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " value"}, 32'(u_bus), 32'(e.v));
        check({e.tag, " carry"}, 32'(carry_flag), 32'(e.c));
        check({e.tag, " R6 zero"}, 32'(zero_flag), 32'(e.v == 16'h0));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 u_valid in reset", 32'(u_valid), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 u_valid after reset", 32'(u_valid), 32'h0);
    for (int i = 0; i < 8; i++) issue("R1 reset reg", A_PR, P_PASS, 3'(i), 3'(0), 0, 0, 0, 3'(0));

    load(3'd1, 16'h0958, 0); load(3'd2, 16'h0467, 0);
    load(3'd3, 16'h1234, 0); load(3'd4, 16'hFFFF, 0);
    load(3'd5, 16'h9999, 0); load(3'd6, 16'h0001, 0);
    idle(1);

    issue("R3 add",   A_ADD, P_PASS, 3'd3, 3'd4, 0, 0, 0, 3'd0);
    issue("R3 sub",   A_SUB, P_PASS, 3'd3, 3'd4, 0, 0, 0, 3'd0);
    issue("R3 sub2",  A_SUB, P_PASS, 3'd4, 3'd3, 0, 0, 0, 3'd0);
    issue("R3 and",   A_AND, P_PASS, 3'd1, 3'd3, 0, 0, 0, 3'd0);
    issue("R3 or",    A_OR,  P_PASS, 3'd1, 3'd2, 0, 0, 0, 3'd0);
    issue("R3 xor",   A_XOR, P_PASS, 3'd4, 3'd4, 0, 0, 0, 3'd0);
    issue("R3 passS", A_PS,  P_PASS, 3'd1, 3'd2, 0, 0, 0, 3'd0);
    issue("R3 inc",   A_INC, P_PASS, 3'd4, 3'd0, 0, 0, 0, 3'd0);

    issue("R4 shl",   A_PR, P_SHL,  3'd3, 3'd0, 0, 0, 0, 3'd0);
    issue("R4 shr",   A_PR, P_SHR,  3'd4, 3'd0, 0, 0, 0, 3'd0);
    issue("R4 swap",  A_PR, P_SWAP, 3'd3, 3'd0, 0, 0, 0, 3'd0);
    issue("R4 swapu", A_PR, P_SCU,  3'd3, 3'd0, 0, 0, 0, 3'd0);
    issue("R4 swapl", A_PR, P_SCL,  3'd3, 3'd0, 0, 0, 0, 3'd0);
    issue("R4 code7", A_PR, P_RSV,  3'd3, 3'd0, 0, 0, 0, 3'd0);

    issue("R5 bcd",      A_ADD, P_DEC, 3'd1, 3'd2, 0, 0, 0, 3'd0);
    issue("R5 bcd wrap", A_ADD, P_DEC, 3'd5, 3'd6, 0, 0, 0, 3'd0);
    issue("R5 bcd big",  A_ADD, P_DEC, 3'd5, 3'd5, 0, 0, 0, 3'd0);

    issue("R7 store",    A_ADD, P_PASS, 3'd1, 3'd2, 0, 0, 1, 3'd7);
    issue("R7 nostore",  A_XOR, P_PASS, 3'd3, 3'd4, 0, 0, 0, 3'd6);
    idle(2);
    issue("R7 read r7",  A_PR, P_PASS, 3'd7, 3'd0, 0, 0, 0, 3'd0);
    issue("R7 read r6",  A_PR, P_PASS, 3'd6, 3'd0, 0, 0, 0, 3'd0);

    issue("R8 producer", A_PR,  P_PASS, 3'd3, 3'd0, 0, 0, 1, 3'd0);
    issue("R8 consumer", A_ADD, P_PASS, 3'd0, 3'd0, 0, 0, 0, 3'd0);
    issue("R8 prod2",    A_INC, P_PASS, 3'd4, 3'd0, 0, 0, 1, 3'd2);
    issue("R8 cons S",   A_PS,  P_PASS, 3'd1, 3'd2, 0, 0, 0, 3'd0);

    issue("R9 source",   A_PR,  P_PASS, 3'd3, 3'd0, 0, 0, 0, 3'd0);
    issue("R9 fb R",     A_ADD, P_PASS, 3'd0, 3'd4, 1, 0, 0, 3'd0);
    issue("R9 fb S",     A_SUB, P_PASS, 3'd3, 3'd0, 0, 1, 0, 3'd0);

    issue("R10 store",   A_PR, P_PASS, 3'd1, 3'd0, 0, 0, 1, 3'd3);
    load(3'd3, 16'hBEEF, 1);
    idle(1);
    issue("R10 winner",  A_PR, P_PASS, 3'd3, 3'd0, 0, 0, 0, 3'd0);
    load(3'd5, 16'h4321, 0);
    idle(1);
    issue("R10 load",    A_PR, P_PASS, 3'd5, 3'd0, 0, 0, 0, 3'd0);

    idle(1);
    @(negedge clk);
    check("R11 idle u_valid", 32'(u_valid), 32'h0);
    issue("R11 regs kept", A_XOR, P_PASS, 3'd1, 3'd7, 0, 0, 0, 3'd0);
    idle(3);
    check("R2 all results seen", 32'(sb_q.size()), 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule